// File: doc/BRIEF.md
# Multi-channel compare match timer

A memory-mapped timer with a parameterised number of independent counting channels. A single run register at the base of the map holds one run bit per channel. Each channel has a prescaler that divides the input clock, an up-counter, a compare register and a control/status word. The control/status word selects the division ratio and the match mode, and it holds the match and overflow flags.

In the default mode the counter returns to zero on the count after it equals the compare value, so the period is compare+1 counts. In free-running mode the counter covers the whole counter range, and a wrap from all-ones that is not a match raises the overflow flag. Software writes the counter through a pending stage. A busy bit shows while the write is in flight. The interrupt output is the OR, over all channels, of the match flag gated by the channel's interrupt enable.

Top module: `cmt_top`

## Requirements
- R1: After reset, the run register, every control/status word and every counter read 0, every compare register reads 0xFFFFFFFF, and `irq` is low.
- R2: Byte address 0x00 holds the run register, with bit n belonging to channel n. Channel n has control/status at 0x10+n*0x10, the counter at +0x4 and compare at +0x8. A read of an address that maps to nothing returns 0.
- R3: Channel n counts only while run bit n is 1. A stopped channel holds its count. Stopping one channel does not disturb the others. The prescaler of a stopped channel restarts its division from zero.
- R4: Control/status bits 2:0 select the count rate: 7 counts every input clock, 4 counts every 8 clocks, 5 every 32 and 6 every 128. The values 0 to 3 do not count.
- R5: With control/status bit 8 at 0, a count taken while the counter equals the compare value sets bit 15 (match flag) and makes the next counter value 0.
- R6: With bit 8 at 1, a count taken at the compare value sets bit 15, and the counter carries on to compare+1.
- R7: With bit 8 at 1, a count from all-ones to 0 that is not a match sets bit 14 (overflow flag).
- R8: Writing 0 to bit 15 or to bit 14 clears that flag. Writing 1 leaves it unchanged. A flag event in the same cycle wins over the clear.
- R9: After a counter write, control/status bit 13 reads 1 for LOAD_LAT clocks. The counter then takes the written value.
- R10: A counter write made while bit 13 is 1 is ignored.
- R11: `irq` is high when any channel has bit 15 and bit 7 (interrupt enable) both set. The overflow flag does not drive `irq`.
- R12: A read presented in a cycle returns its data on `bus_rdata` after the next clock edge. Writable fields read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined match interrupt |

## Verification
The bench builds the block with three channels, 32-bit counters and a load latency of 3 clocks. The third channel is there so that the /32 and /128 rates can be run on a channel whose count is not disturbed by the other tests. Three channels also make stopping one channel while another runs observable. The 32-bit width lets a counter preloaded to just below all-ones reach the overflow wrap within a few counts.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PRE_W    = 7;   // prescaler count width, largest ratio 128

  localparam int unsigned BIT_MF   = 15;
  localparam int unsigned BIT_OF   = 14;
  localparam int unsigned BIT_BUSY = 13;
  localparam int unsigned BIT_MODE = 8;
  localparam int unsigned BIT_IE   = 7;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMP  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       free_run;
    logic       irq_en;
    logic [1:0] req;
    logic [2:0] rate;
  } chan_cfg_t;

  // division ratio for a rate code, 0 means the channel does not count
  function automatic logic [PRE_W:0] ratio_of(input logic [2:0] rate);
    logic [PRE_W:0] r;
    case (rate)
      3'd7:    r = (PRE_W+1)'(1);
      3'd4:    r = (PRE_W+1)'(8);
      3'd5:    r = (PRE_W+1)'(32);
      3'd6:    r = (PRE_W+1)'(128);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       tick
);

  localparam logic [PRE_W:0] ONE = (PRE_W+1)'(1);

  logic [PRE_W-1:0] pc_q, pc_d;
  logic [PRE_W:0]   ratio;
  logic             active;

  always_comb begin
    ratio  = ratio_of(rate);
    active = run && (ratio != '0);
    tick   = active && ({1'b0, pc_q} >= (ratio - ONE));
    pc_d   = pc_q;
    if (!active || tick) pc_d = '0;
    else                 pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LOAD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_ctrl,
  input  logic              wr_cnt,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic [DATA_W-1:0] cmp_rd,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cmp,
  output logic              mf,
  output logic              of,
  output logic              busy,
  output logic              mode,
  output logic              irq
);

  localparam int unsigned LAT_W        = $clog2(LOAD_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_END = LAT_W'(LOAD_LAT - 1);

  chan_cfg_t        cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d, pend_q, pend_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             mf_q, mf_d, of_q, of_d, busy_q, busy_d;
  logic             tick, match_ev, ovf_ev, load;

  cmt_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .rate (cfg_q.rate),
    .tick (tick)
  );

  always_comb begin
    match_ev = tick && (cnt_q == cmp_q);
    ovf_ev   = tick && cfg_q.free_run && (&cnt_q) && !match_ev;
    load     = busy_q && (lat_q == LAT_END);

    cnt_d = cnt_q;
    if (load)
      cnt_d = pend_q;
    else if (tick)
      cnt_d = (match_ev && !cfg_q.free_run) ? '0 : cnt_q + 1'b1;

    mf_d = mf_q;
    if (wr_ctrl) mf_d = mf_q & wdata[BIT_MF];
    if (match_ev) mf_d = 1'b1;

    of_d = of_q;
    if (wr_ctrl) of_d = of_q & wdata[BIT_OF];
    if (ovf_ev) of_d = 1'b1;

    cfg_d = cfg_q;
    if (wr_ctrl) begin
      cfg_d.free_run = wdata[BIT_MODE];
      cfg_d.irq_en   = wdata[BIT_IE];
      cfg_d.req      = wdata[5:4];
      cfg_d.rate     = wdata[2:0];
    end

    busy_d = busy_q;
    pend_d = pend_q;
    lat_d  = lat_q;
    if (wr_cnt && !busy_q) begin
      busy_d = 1'b1;
      pend_d = wdata[CNT_W-1:0];
      lat_d  = '0;
    end else if (busy_q) begin
      if (load) busy_d = 1'b0;
      else      lat_d  = lat_q + 1'b1;
    end

    cmp_d = wr_cmp ? wdata[CNT_W-1:0] : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      cmp_q  <= '1;
      pend_q <= '0;
      lat_q  <= '0;
      mf_q   <= 1'b0;
      of_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      pend_q <= pend_d;
      lat_q  <= lat_d;
      mf_q   <= mf_d;
      of_q   <= of_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    ctrl_rd = {16'h0000, mf_q, of_q, busy_q, 4'h0, cfg_q.free_run, cfg_q.irq_en,
               1'b0, cfg_q.req, 1'b0, cfg_q.rate};
    cnt_rd  = '0;
    cnt_rd[CNT_W-1:0] = cnt_q;
    cmp_rd  = '0;
    cmp_rd[CNT_W-1:0] = cmp_q;
  end

  assign cnt  = cnt_q;
  assign cmp  = cmp_q;
  assign mf   = mf_q;
  assign of   = of_q;
  assign busy = busy_q;
  assign mode = cfg_q.free_run;
  assign irq  = mf_q && cfg_q.irq_en;

endmodule

// File: rtl/cmt_top.sv
module cmt_top
  import cmt_pkg::*;
#(
  parameter int unsigned NCH      = 2,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned LOAD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam int unsigned BLK_W = ADDR_W - 4;

  logic [1:0]                   rs_q;
  logic                         rst_core_n;
  logic [NCH-1:0]               run_q, run_d;
  logic [31:0]                  rdata_q, rdata_d;
  logic [BLK_W-1:0]             blk;
  logic [1:0]                   word;
  logic                         run_hit;
  logic [NCH-1:0]               hit_v, wr_ctrl_v, wr_cnt_v, wr_cmp_v;
  logic [NCH-1:0]               busy_v, mf_v, of_v, mode_v, irq_v;
  logic [NCH-1:0][CNT_W-1:0]    cnt_v, cmp_v;
  logic [NCH-1:0][31:0]         ch_rd_v;
  logic                         unused_addr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign blk         = bus_addr[ADDR_W-1:4];
  assign word        = bus_addr[3:2];
  assign run_hit     = bus_sel && (blk == '0) && (word == 2'd0);
  assign unused_addr = ^bus_addr[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [BLK_W-1:0] BLK = BLK_W'(g + 1);
    logic [31:0] ctrl_rd, cnt_rd, cmp_rd;

    assign hit_v[g]     = bus_sel && (blk == BLK);
    assign wr_ctrl_v[g] = hit_v[g] && bus_wr && (word == REG_CTRL);
    assign wr_cnt_v[g]  = hit_v[g] && bus_wr && (word == REG_CNT);
    assign wr_cmp_v[g]  = hit_v[g] && bus_wr && (word == REG_CMP);

    cmt_channel #(
      .CNT_W   (CNT_W),
      .LOAD_LAT(LOAD_LAT)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .run    (run_q[g]),
      .wr_ctrl(wr_ctrl_v[g]),
      .wr_cnt (wr_cnt_v[g]),
      .wr_cmp (wr_cmp_v[g]),
      .wdata  (bus_wdata),
      .ctrl_rd(ctrl_rd),
      .cnt_rd (cnt_rd),
      .cmp_rd (cmp_rd),
      .cnt    (cnt_v[g]),
      .cmp    (cmp_v[g]),
      .mf     (mf_v[g]),
      .of     (of_v[g]),
      .busy   (busy_v[g]),
      .mode   (mode_v[g]),
      .irq    (irq_v[g])
    );

    always_comb begin
      case (word)
        REG_CTRL: ch_rd_v[g] = ctrl_rd;
        REG_CNT:  ch_rd_v[g] = cnt_rd;
        REG_CMP:  ch_rd_v[g] = cmp_rd;
        default:  ch_rd_v[g] = '0;
      endcase
    end
  end

  always_comb begin
    run_d = run_q;
    if (run_hit && bus_wr) run_d = bus_wdata[NCH-1:0];

    rdata_d = '0;
    if (run_hit) rdata_d[NCH-1:0] = run_q;
    for (int k = 0; k < NCH; k++)
      if (hit_v[k]) rdata_d = ch_rd_v[k];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q   <= '0;
      rdata_q <= '0;
    end else begin
      run_q <= run_d;
      if (bus_sel && !bus_wr) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |irq_v;

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned CNT_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0]            busy,
  input logic [NCH-1:0]            mf,
  input logic [NCH-1:0]            of,
  input logic [NCH-1:0]            mode,
  input logic [NCH-1:0]            wr_ctrl,
  input logic [NCH-1:0]            wr_cnt,
  input logic [31:0]               wdata,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][CNT_W-1:0] cmp
);

  logic [NCH-1:0][CNT_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else
      for (int i = 0; i < NCH; i++)
        if (wr_cnt[i] && !busy[i]) shadow_q[i] <= wdata[CNT_W-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !busy[i]) |=> $stable(cnt[i]))
      else $error("stopped channel changed its count"); // R3

    AST_MATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mf[i]) |-> $past(cnt[i] == cmp[i]))
      else $error("match flag without equal compare"); // R5

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(of[i]) |-> $past(mode[i] && (&cnt[i]) && !(&cmp[i])))
      else $error("overflow flag without a wrap"); // R7

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mf[i]) |-> $past(wr_ctrl[i] && !wdata[15]))
      else $error("match flag dropped without a clearing write"); // R8

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[i]) |-> (cnt[i] == shadow_q[i]))
      else $error("counter load value wrong"); // R9
  end

endmodule

bind cmt_top cmt_checker #(
  .NCH  (NCH),
  .CNT_W(CNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (run_q),
  .busy   (busy_v),
  .mf     (mf_v),
  .of     (of_v),
  .mode   (mode_v),
  .wr_ctrl(wr_ctrl_v),
  .wr_cnt (wr_cnt_v),
  .wdata  (bus_wdata),
  .cnt    (cnt_v),
  .cmp    (cmp_v)
);

// File: tb/sim_cmt_top.sv
`timescale 1ns/1ps
module sim_cmt_top;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen;

  cmt_top #(.NCH(3), .CNT_W(32), .ADDR_W(8), .LOAD_LAT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: a read presented before an edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= rst_n && bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  // tasks are entered at a falling edge; each access takes one edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    rd(8'h18, 32'hFFFF_FFFF, "R1");
    rd(8'h28, 32'hFFFF_FFFF, "R1");
    rd(8'h80, 32'h0, "R2");

    // R9 / R10 counter write path on a stopped channel
    wr(8'h14, 32'd100);
    rd(8'h10, 32'h0000_2000, "R9");
    wr(8'h14, 32'd200);
    idle(4);
    rd(8'h14, 32'd100, "R10");
    rd(8'h10, 32'h0, "R9");

    // R5 clear on match, 7 counts at full rate with compare 4
    wr(8'h14, 32'd0);
    idle(4);
    wr(8'h18, 32'd4);
    wr(8'h10, 32'h0000_0087);
    wr(8'h00, 32'h1);
    idle(6);
    wr(8'h00, 32'h0);
    rd(8'h14, 32'd2, "R5");
    rd(8'h10, 32'h0000_8087, "R5");
    chk_irq(1'b1, "R11");

    // R8 write-zero-to-clear
    wr(8'h10, 32'h0000_8087);
    rd(8'h10, 32'h0000_8087, "R8");
    wr(8'h10, 32'h0000_0087);
    rd(8'h10, 32'h0000_0087, "R8");
    chk_irq(1'b0, "R11");

    // R11 flag without enable keeps irq low; 3 counts from 2 reach match
    wr(8'h10, 32'h0000_0007);
    wr(8'h00, 32'h1);
    idle(2);
    wr(8'h00, 32'h0);
    rd(8'h10, 32'h0000_8007, "R11");
    chk_irq(1'b0, "R11");
    rd(8'h14, 32'd0, "R5");
    wr(8'h10, 32'h0000_0000);

    // R4 rate codes
    wr(8'h20, 32'h0000_0004);
    wr(8'h00, 32'h2);
    idle(19);
    wr(8'h00, 32'h0);
    rd(8'h24, 32'd2, "R4");
    rd(8'h14, 32'd0, "R3");
    wr(8'h30, 32'h0000_0005);
    wr(8'h00, 32'h4);
    idle(69);
    wr(8'h00, 32'h0);
    rd(8'h34, 32'd2, "R4");
    wr(8'h30, 32'h0000_0006);
    wr(8'h00, 32'h4);
    idle(255);
    wr(8'h00, 32'h0);
    rd(8'h34, 32'd4, "R4");
    wr(8'h20, 32'h0000_0001);
    wr(8'h00, 32'h2);
    idle(10);
    wr(8'h00, 32'h0);
    rd(8'h24, 32'd2, "R4");

    // R3 independent run bits
    wr(8'h30, 32'h0000_0000);
    wr(8'h00, 32'h4);
    rd(8'h00, 32'h4, "R2");
    wr(8'h00, 32'h0);
    rd(8'h34, 32'd4, "R3");
    wr(8'h10, 32'h0000_0007);
    wr(8'h18, 32'd100);
    wr(8'h20, 32'h0000_0007);
    wr(8'h00, 32'h3);
    idle(4);
    wr(8'h00, 32'h1);
    idle(3);
    wr(8'h00, 32'h0);
    rd(8'h14, 32'd9, "R3");
    rd(8'h24, 32'd7, "R3");
    rd(8'h00, 32'h0, "R3");

    // R7 overflow in free-running mode
    wr(8'h10, 32'h0000_0187);
    wr(8'h18, 32'd5);
    wr(8'h14, 32'hFFFF_FFFE);
    idle(4);
    wr(8'h00, 32'h1);
    idle(2);
    wr(8'h00, 32'h0);
    rd(8'h14, 32'd1, "R7");
    rd(8'h10, 32'h0000_4187, "R7");
    chk_irq(1'b0, "R11");

    // R6 match without clearing
    wr(8'h18, 32'd3);
    rd(8'h18, 32'd3, "R12");
    wr(8'h00, 32'h1);
    idle(3);
    wr(8'h00, 32'h0);
    rd(8'h14, 32'd5, "R6");
    rd(8'h10, 32'h0000_C187, "R6");
    chk_irq(1'b1, "R11");
    wr(8'h10, 32'h0000_0187);
    rd(8'h10, 32'h0000_0187, "R8");
    chk_irq(1'b0, "R8");

    idle(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule